// File: doc/BRIEF.md
# Data Space Address Decoder

This block sits between a CPU load/store port and the memories behind it. It decodes each 16-bit data-space address into one of four on-chip targets: the working register file, the standard I/O window, the extended I/O window or the internal SRAM. For an on-chip hit it raises a one-hot select and gives the offset of the address inside that target. Any address above the on-chip range goes to an external SRAM port.

A map input picks one of two layouts. The normal layout has an extended I/O window and a 4096-byte SRAM. The legacy layout has no extended I/O window, and its SRAM is 4000 bytes long. External accesses happen only while the external enable input is high. The block drives separate read and write strobes for them and stretches each one by 0 to 3 wait states. The ready output tells the CPU when the access is done. The CPU must hold the request, address and direction steady until it sees ready.

Top module: `dsd_decoder`

## Requirements
- R1: In the normal map (`map_legacy`=0), addresses 0..31 select the register file, 32..95 select standard I/O, 96..255 select extended I/O and 256..4351 select SRAM. `sel` is a one-hot vector, bit0 = registers, bit1 = standard I/O, bit2 = extended I/O, bit3 = SRAM. `loc_off` is the address minus the base of its region.
- R2: In the legacy map (`map_legacy`=1), extended I/O is never selected. Addresses 96..4095 select SRAM, with offsets counted from 96. The register file and standard I/O ranges are the same as in R1.
- R3: Addresses at or above the end of the on-chip range go to the external port and assert no `sel` bit. That end is 4352 in the normal map and 4096 in the legacy map.
- R4: An on-chip access completes in one clock: `ready` is high in the cycle the request appears. Both external strobes stay low for the whole access.
- R5: An external access with W wait states (`wait_cfg`=W, 0..3) keeps `ready` low for W+1 cycles and raises it in cycle W+2. That is 1+W clocks more than an on-chip access.
- R6: During an external access, `ext_rd` is high for a read (`req_we`=0) and `ext_wr` is high for a write (`req_we`=1). The strobe stays high for every cycle of the access, including the ready cycle. The two strobes are never high together, and both are low when no external access is in progress. `ext_addr` carries the request address while a strobe is high.
- R7: An external address with `ext_en`=0 raises `err` and `ready` in the same cycle and drives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| map_legacy | input | 1 | 1 selects the legacy layout |
| ext_en | input | 1 | Enables the external memory port |
| wait_cfg | input | 2 | Wait states for external accesses |
| req_valid | input | 1 | Load/store request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Data-space address |
| sel | output | 4 | One-hot on-chip target select |
| loc_off | output | 16 | Offset inside the selected region |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | 16 | External address, zero when idle |
| ready | output | 1 | Access completes this cycle |
| err | output | 1 | External access while the port is disabled |

## Verification
The bench drives addresses on both sides of every region edge in both maps. The first and last address of each window shows whether an off-by-one has moved a boundary or an offset base. Address 0x1000 is decoded as SRAM in the normal map and as external in the legacy map, so that one address tells the two layouts apart. External reads and writes are run at every wait-state count, which separates a wrong cycle count from a wrong strobe direction. A final external access with the port disabled checks the error path and confirms that no strobe is raised.

// File: rtl/dsd_decoder.sv
module dsd_decoder #(
  parameter int AW     = 16,
  parameter int WS_W   = 2,
  parameter int REG_N  = 32,
  parameter int IO_N   = 64,
  parameter int XIO_N  = 160,
  parameter int SRAM_N = 4096,
  parameter int LSRAM_N = 4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          map_legacy,
  input  logic          ext_en,
  input  logic [WS_W-1:0] wait_cfg,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  output logic [3:0]    sel,
  output logic [AW-1:0] loc_off,
  output logic          ext_rd,
  output logic          ext_wr,
  output logic [AW-1:0] ext_addr,
  output logic          ready,
  output logic          err
);
  localparam int CW       = WS_W + 1;
  localparam int IO_BASE  = REG_N;
  localparam int XIO_BASE = REG_N + IO_N;
  localparam int N_SBASE  = XIO_BASE + XIO_N;
  localparam int N_END    = N_SBASE + SRAM_N;
  localparam int L_SBASE  = XIO_BASE;
  localparam int L_END    = L_SBASE + LSRAM_N;

  logic [AW-1:0] sbase, send, base;
  logic is_reg, is_io, is_xio, is_sram, is_ext, ext_go;
  logic [CW-1:0] cnt;
  logic last;

  assign sbase   = map_legacy ? AW'(L_SBASE) : AW'(N_SBASE);
  assign send    = map_legacy ? AW'(L_END)   : AW'(N_END);
  assign is_reg  = req_addr < AW'(IO_BASE);
  assign is_io   = !is_reg && req_addr < AW'(XIO_BASE);
  assign is_xio  = !map_legacy && req_addr >= AW'(XIO_BASE) && req_addr < AW'(N_SBASE);
  assign is_sram = req_addr >= sbase && req_addr < send;
  assign is_ext  = req_addr >= send;

  always_comb begin
    base = '0;
    if (is_io)   base = AW'(IO_BASE);
    if (is_xio)  base = AW'(XIO_BASE);
    if (is_sram) base = sbase;
  end

  assign loc_off = req_addr - base;
  assign sel     = req_valid ? {is_sram, is_xio, is_io, is_reg} : 4'b0;

  assign ext_go   = req_valid && is_ext && ext_en;
  assign err      = req_valid && is_ext && !ext_en;
  assign ext_rd   = ext_go && !req_we;
  assign ext_wr   = ext_go && req_we;
  assign ext_addr = ext_go ? req_addr : '0;
  assign last     = cnt == CW'(wait_cfg) + CW'(1);
  assign ready    = req_valid && (!is_ext || !ext_en || last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= '0;
    else if (ext_go && !last)  cnt <= cnt + CW'(1);
    else                       cnt <= '0;
endmodule

module dsd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  wait_cfg,
  input logic        req_valid,
  input logic [3:0]  sel,
  input logic        ext_rd,
  input logic        ext_wr,
  input logic        ready,
  input logic        err
);
  logic [2:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           run <= '0;
    else if ((ext_rd || ext_wr) && !ready) run <= run + 3'd1;
    else                                  run <= '0;

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));
  assert_onchip_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel != 4'b0) |-> (!ext_rd && !ext_wr && ready));
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_rd || ext_wr) && ready) |-> (run == {1'b0, wait_cfg} + 3'd1));
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n) !(ext_rd && ext_wr));
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!ext_rd && !ext_wr && !ready));
  assert_err_nostrobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!ext_rd && !ext_wr && ready && sel == 4'b0));
endmodule

bind dsd_decoder dsd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wait_cfg(wait_cfg), .req_valid(req_valid),
  .sel(sel), .ext_rd(ext_rd), .ext_wr(ext_wr), .ready(ready), .err(err)
);

// File: tb/tb_dsd_decoder.sv
module tb_dsd_decoder;
  logic clk = 0, rst_n = 0;
  logic map_legacy = 0, ext_en = 0, req_valid = 0, req_we = 0;
  logic [1:0] wait_cfg = 0;
  logic [15:0] req_addr = 0;
  logic [3:0] sel;
  logic [15:0] loc_off, ext_addr;
  logic ext_rd, ext_wr, ready, err;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dsd_decoder dut (.clk(clk), .rst_n(rst_n), .map_legacy(map_legacy), .ext_en(ext_en),
    .wait_cfg(wait_cfg), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .sel(sel), .loc_off(loc_off), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr),
    .ready(ready), .err(err));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic onchip(string req, logic leg, logic [15:0] a, logic [3:0] esel, logic [15:0] eoff);
    @(negedge clk);
    map_legacy = leg; req_addr = a; req_we = a[0]; req_valid = 1;
    #1;
    chk(req, {28'b0, sel}, {28'b0, esel});
    chk(req, {16'b0, loc_off}, {16'b0, eoff});
    chk("R4", {29'b0, ready, ext_rd, ext_wr}, 32'b100);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic external(string req, logic leg, logic [15:0] a, logic we, logic [1:0] w);
    int n = 1;
    @(negedge clk);
    map_legacy = leg; ext_en = 1; wait_cfg = w; req_addr = a; req_we = we; req_valid = 1;
    #1;
    chk(req, {28'b0, sel}, 32'd0);
    chk("R6", {30'b0, ext_rd, ext_wr}, we ? 32'b01 : 32'b10);
    chk("R6", {16'b0, ext_addr}, {16'b0, a});
    while (!ready && n < 10) begin
      @(negedge clk); #1; n++;
      if (!ready) chk("R6", {30'b0, ext_rd, ext_wr}, we ? 32'b01 : 32'b10);
    end
    chk("R5", n, w + 2);
    @(negedge clk); req_valid = 0; #1;
    chk("R6", {30'b0, ext_rd, ext_wr}, 0);
  endtask

  task automatic disabled_ext();
    @(negedge clk);
    map_legacy = 0; ext_en = 0; req_addr = 16'hF000; req_we = 1; req_valid = 1;
    #1;
    chk("R7", {28'b0, ext_rd, ext_wr, ready, err}, 32'b0011);
    chk("R7", {16'b0, ext_addr}, 0);
    @(negedge clk); req_valid = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    #1;
    chk("R4", {28'b0, sel, ready, ext_rd, ext_wr, err} , 0);
    onchip("R1", 0, 16'h0000, 4'b0001, 0);
    onchip("R1", 0, 16'h001F, 4'b0001, 31);
    onchip("R1", 0, 16'h0020, 4'b0010, 0);
    onchip("R1", 0, 16'h005F, 4'b0010, 63);
    onchip("R1", 0, 16'h0060, 4'b0100, 0);
    onchip("R1", 0, 16'h00FF, 4'b0100, 159);
    onchip("R1", 0, 16'h0100, 4'b1000, 0);
    onchip("R1", 0, 16'h1000, 4'b1000, 3840);
    onchip("R1", 0, 16'h10FF, 4'b1000, 4095);
    onchip("R2", 1, 16'h0021, 4'b0010, 1);
    onchip("R2", 1, 16'h0060, 4'b1000, 0);
    onchip("R2", 1, 16'h00FF, 4'b1000, 159);
    onchip("R2", 1, 16'h0FFF, 4'b1000, 3999);
    external("R3", 0, 16'h1100, 0, 0);
    external("R3", 1, 16'h1000, 1, 0);
    external("R3", 1, 16'h10FF, 0, 1);
    external("R5", 0, 16'hFFFF, 1, 1);
    external("R5", 0, 16'h2000, 0, 2);
    external("R5", 0, 16'h2001, 1, 3);
    external("R5", 1, 16'h8000, 0, 3);
    disabled_ext();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule